// File: doc/BRIEF.md
# Configuration Space Address/Data Port Bridge

This block sits on the host side of an I/O-style bus and gives software indirect access to a downstream configuration space through two small port windows. The first window is a 32-bit selector register. Software writes it with an enable flag, a bus number, a device/function number and a dword-aligned register offset. The second window is four bytes wide. Each byte, word or dword access to it becomes one configuration read or write request. The request carries the bus, the device/function, the final register byte address, the access size and the byte lane.

The host issues one access at a time with a single-cycle `io_req` strobe. For any access that lands in one of the two windows, it waits for the one-cycle `io_done` pulse. Accesses that cannot be forwarded are answered locally in the next cycle. This covers a disabled selector, an access running past the end of the data window, and a reserved size code. The request side uses a valid/ready handshake. Read data comes back later on a separate response strobe.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the selector register reads as zero, `io_done` is low and `cfg_valid` is low.
- R2: A dword access (`io_size`=2) at the selector port base (default 0x0CF8) writes the selector or reads back exactly the last value written. `io_done` pulses one cycle after the access.
- R3: Any other access inside the 4-byte selector window leaves the selector unchanged, reads as 0xFFFFFFFF and completes one cycle later. This covers byte or word sizes, a nonzero offset and the reserved size code.
- R4: While selector bit 31 is clear, a data window access raises no request. A read returns 0xFFFFFFFF, a write is dropped, and `io_done` pulses one cycle later.
- R5: A data window access whose offset plus byte count exceeds 4, or that uses the reserved size code 3, is handled like R4 even when bit 31 is set.
- R6: A forwarded access raises `cfg_valid` one cycle after `io_req`. The fields are set as follows. `cfg_addr[23:16]` is selector bits 23:16. `cfg_addr[15:8]` is selector bits 15:8. `cfg_addr[7:0]` is selector bits 7:2 followed by the window offset (port bits 1:0). `cfg_lane` is the window offset. `cfg_size` is 1, 2 or 4 for `io_size` codes 0, 1, 2.
- R7: `cfg_valid` and every request field stay constant until the cycle in which `cfg_ready` is high.
- R8: On a forwarded write, `cfg_wdata` is `io_wdata` with bytes above the access size cleared. `io_done` pulses in the cycle after the handshake.
- R9: On a forwarded read, `io_done` stays low until `cfg_rsp_valid`. It pulses in the following cycle, with `io_rdata` equal to `cfg_rsp_data` with bytes above the access size cleared.
- R10: An access to a port outside both windows produces no `io_done` and no request.
- R11: Every claimed access produces exactly one single-cycle `io_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_req | input | 1 | One-cycle access strobe from the host |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | IO_AW | I/O port address |
| io_size | input | 2 | 0 byte, 1 word, 2 dword, 3 reserved |
| io_wdata | input | 32 | Write data, right-justified |
| io_done | output | 1 | Access complete pulse |
| io_rdata | output | 32 | Read data, valid with `io_done` |
| cfg_valid | output | 1 | Configuration request valid |
| cfg_ready | input | 1 | Configuration side accepts the request |
| cfg_we | output | 1 | Request is a write |
| cfg_addr | output | 24 | Bus, device/function, register byte address |
| cfg_size | output | 3 | Access size in bytes |
| cfg_lane | output | 2 | Starting byte lane within the dword |
| cfg_wdata | output | 32 | Write data, right-justified and size-masked |
| cfg_rsp_valid | input | 1 | Read response strobe |
| cfg_rsp_data | input | 32 | Read response data, right-justified |

## Verification
Results answered locally are due one cycle after the accepting edge. This covers selector accesses, refused data window accesses, and the first cycle of `cfg_valid` for a forwarded access. A write's `io_done` is due one cycle after the edge where `cfg_valid` and `cfg_ready` meet. A read's `io_done` is due one cycle after the edge that carries `cfg_rsp_valid`. The bench drives and samples on falling edges. It counts those edges from each stimulus and checks each result at the exact edge it is due, not by polling. Between stimulus and completion it also checks that `io_done` stays low and that the request fields stay stable.

// File: rtl/cfgbr_pkg.sv
// Shared types and helpers for the configuration port bridge.
// Assumes a 32-bit data path with right-justified sub-dword data.
package cfgbr_pkg;

    localparam int CFG_DW = 32;
    localparam int CFG_AW = 24;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_DWORD = 2'b10,
        SZ_RSVD  = 2'b11
    } io_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } eng_state_e;

    // Byte count for a host size code; zero marks the reserved code.
    function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
        case (code)
            SZ_BYTE:  return 3'd1;
            SZ_WORD:  return 3'd2;
            SZ_DWORD: return 3'd4;
            default:  return 3'd0;
        endcase
    endfunction

    // Keeps the low nbytes bytes of a right-justified word.
    function automatic logic [CFG_DW-1:0] lane_mask(input logic [2:0] nbytes);
        case (nbytes)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            3'd4:    return 32'hFFFF_FFFF;
            default: return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/cfgbr_decode.sv
// Port decoder: classifies a host access against the selector window
// and the data window. Purely combinational. Assumes both window bases
// are 4-byte aligned.
module cfgbr_decode
    import cfgbr_pkg::*;
#(
    parameter int               IO_AW     = 16,
    parameter logic [IO_AW-1:0] SEL_PORT  = 16'h0CF8,
    parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC
) (
    input  logic [IO_AW-1:0] io_addr,
    input  logic [1:0]       io_size,
    output logic             hit_sel,
    output logic             hit_data,
    output logic             sel_ok,
    output logic             data_ok,
    output logic [1:0]       offset,
    output logic [2:0]       nbytes
);
    localparam int WIN_HI = IO_AW - 1;

    logic [3:0] span_end;

    // Window match, offset and size classification.
    always_comb begin
        hit_sel  = (io_addr[WIN_HI:2] == SEL_PORT[WIN_HI:2]);
        hit_data = (io_addr[WIN_HI:2] == DATA_PORT[WIN_HI:2]);
        offset   = io_addr[1:0];
        nbytes   = size_to_bytes(io_size);
        span_end = {2'b00, offset} + {1'b0, nbytes};
        sel_ok   = hit_sel && (offset == 2'd0) && (io_size == SZ_DWORD);
        data_ok  = hit_data && (nbytes != 3'd0) && (span_end <= 4'd4);
    end

endmodule

// File: rtl/cfgbr_sel_reg.sv
// Selector register: holds the full 32-bit value written through the
// selector port and splits out the fields used to form requests.
module cfgbr_sel_reg
    import cfgbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_DW-1:0] wr_data,
    output logic [CFG_DW-1:0] q,
    output logic              enable,
    output logic [7:0]        bus_num,
    output logic [7:0]        devfn,
    output logic [5:0]        dword_idx
);
    // Latch the selector on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wr_data;
        end
    end

    // Field split.
    always_comb begin
        enable    = q[31];
        bus_num   = q[23:16];
        devfn     = q[15:8];
        dword_idx = q[7:2];
    end

endmodule

// File: rtl/cfgbr_engine.sv
// Access engine: answers selector and refused accesses locally, and
// forwards valid data window accesses as configuration requests with a
// valid/ready handshake, then returns the read response. Assumes the
// host issues a new access only after io_done, and that read responses
// arrive after the request handshake.
module cfgbr_engine
    import cfgbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_req,
    input  logic              io_we,
    input  logic [CFG_DW-1:0] io_wdata,
    input  logic              hit_sel,
    input  logic              hit_data,
    input  logic              sel_ok,
    input  logic              data_ok,
    input  logic [1:0]        offset,
    input  logic [2:0]        nbytes,
    input  logic [CFG_DW-1:0] sel_q,
    input  logic              enable,
    input  logic [7:0]        bus_num,
    input  logic [7:0]        devfn,
    input  logic [5:0]        dword_idx,
    output logic              sel_wr,
    output logic              io_done,
    output logic [CFG_DW-1:0] io_rdata,
    output logic              cfg_valid,
    input  logic              cfg_ready,
    output logic              cfg_we,
    output logic [CFG_AW-1:0] cfg_addr,
    output logic [2:0]        cfg_size,
    output logic [1:0]        cfg_lane,
    output logic [CFG_DW-1:0] cfg_wdata,
    input  logic              cfg_rsp_valid,
    input  logic [CFG_DW-1:0] cfg_rsp_data
);
    eng_state_e state;
    logic       take;

    // An access is taken only when the engine is idle.
    assign take   = io_req && (state == ST_IDLE);
    assign sel_wr = take && io_we && sel_ok;

    // Sequencing of local answers, request issue and response return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            io_done   <= 1'b0;
            io_rdata  <= '0;
            cfg_valid <= 1'b0;
            cfg_we    <= 1'b0;
            cfg_addr  <= '0;
            cfg_size  <= '0;
            cfg_lane  <= '0;
            cfg_wdata <= '0;
        end else begin
            io_done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (take && hit_sel) begin
                        io_done  <= 1'b1;
                        io_rdata <= sel_ok ? sel_q : '1;
                    end else if (take && hit_data) begin
                        if (enable && data_ok) begin
                            state     <= ST_REQ;
                            cfg_valid <= 1'b1;
                            cfg_we    <= io_we;
                            cfg_addr  <= {bus_num, devfn, dword_idx, offset};
                            cfg_size  <= nbytes;
                            cfg_lane  <= offset;
                            cfg_wdata <= io_wdata & lane_mask(nbytes);
                        end else begin
                            io_done  <= 1'b1;
                            io_rdata <= '1;
                        end
                    end
                end
                ST_REQ: begin
                    if (cfg_ready) begin
                        cfg_valid <= 1'b0;
                        if (cfg_we) begin
                            io_done <= 1'b1;
                            state   <= ST_IDLE;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (cfg_rsp_valid) begin
                        io_rdata <= cfg_rsp_data & lane_mask(cfg_size);
                        io_done  <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7: request held steady until accepted.
    a_r7_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_addr) && $stable(cfg_size)
            && $stable(cfg_we) && $stable(cfg_wdata) && $stable(cfg_lane));

    // R6: size is a legal byte count and the access fits the dword.
    a_r6_size_fits: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> ((cfg_size == 3'd1) || (cfg_size == 3'd2) || (cfg_size == 3'd4))
            && (({2'b00, cfg_lane} + {1'b0, cfg_size}) <= 4'd4));

    // R4: a request only starts while the selector enable was set.
    a_r4_enable_needed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_valid) |-> $past(enable));

    // R11: completion is a single-cycle pulse.
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        io_done |=> !io_done);

    // R9: a read handshake does not complete the access by itself.
    a_r9_read_waits: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_ready && !cfg_we |=> !io_done);

    // R10: unclaimed ports cause neither completion nor request.
    a_r10_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
        io_req && (state == ST_IDLE) && !hit_sel && !hit_data |=> !io_done && !cfg_valid);

endmodule

// File: rtl/cfg_port_bridge.sv
// Top level of the configuration address/data port bridge. Wires the
// port decoder, the selector register and the access engine together.
// Assumes one outstanding host access at a time.
module cfg_port_bridge
    import cfgbr_pkg::*;
#(
    parameter int               IO_AW     = 16,
    parameter logic [IO_AW-1:0] SEL_PORT  = 16'h0CF8,
    parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_req,
    input  logic              io_we,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [1:0]        io_size,
    input  logic [31:0]       io_wdata,
    output logic              io_done,
    output logic [31:0]       io_rdata,
    output logic              cfg_valid,
    input  logic              cfg_ready,
    output logic              cfg_we,
    output logic [23:0]       cfg_addr,
    output logic [2:0]        cfg_size,
    output logic [1:0]        cfg_lane,
    output logic [31:0]       cfg_wdata,
    input  logic              cfg_rsp_valid,
    input  logic [31:0]       cfg_rsp_data
);
    logic              hit_sel, hit_data, sel_ok, data_ok;
    logic [1:0]        offset;
    logic [2:0]        nbytes;
    logic              sel_wr, enable;
    logic [CFG_DW-1:0] sel_q;
    logic [7:0]        bus_num, devfn;
    logic [5:0]        dword_idx;

    cfgbr_decode #(
        .IO_AW    (IO_AW),
        .SEL_PORT (SEL_PORT),
        .DATA_PORT(DATA_PORT)
    ) u_decode (
        .io_addr (io_addr),
        .io_size (io_size),
        .hit_sel (hit_sel),
        .hit_data(hit_data),
        .sel_ok  (sel_ok),
        .data_ok (data_ok),
        .offset  (offset),
        .nbytes  (nbytes)
    );

    cfgbr_sel_reg u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sel_wr),
        .wr_data  (io_wdata),
        .q        (sel_q),
        .enable   (enable),
        .bus_num  (bus_num),
        .devfn    (devfn),
        .dword_idx(dword_idx)
    );

    cfgbr_engine u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .io_req       (io_req),
        .io_we        (io_we),
        .io_wdata     (io_wdata),
        .hit_sel      (hit_sel),
        .hit_data     (hit_data),
        .sel_ok       (sel_ok),
        .data_ok      (data_ok),
        .offset       (offset),
        .nbytes       (nbytes),
        .sel_q        (sel_q),
        .enable       (enable),
        .bus_num      (bus_num),
        .devfn        (devfn),
        .dword_idx    (dword_idx),
        .sel_wr       (sel_wr),
        .io_done      (io_done),
        .io_rdata     (io_rdata),
        .cfg_valid    (cfg_valid),
        .cfg_ready    (cfg_ready),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_size     (cfg_size),
        .cfg_lane     (cfg_lane),
        .cfg_wdata    (cfg_wdata),
        .cfg_rsp_valid(cfg_rsp_valid),
        .cfg_rsp_data (cfg_rsp_data)
    );

    // R3: a non-qualifying selector window access never alters the selector.
    a_r3_sel_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        io_req && hit_sel && !sel_ok |=> $stable(sel_q));

endmodule

// File: tb/cfg_port_bridge_test.sv
module cfg_port_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req = 1'b0, io_we = 1'b0;
    logic [15:0] io_addr = '0;
    logic [1:0]  io_size = '0;
    logic [31:0] io_wdata = '0;
    logic        io_done;
    logic [31:0] io_rdata;
    logic        cfg_valid, cfg_we;
    logic        cfg_ready = 1'b0;
    logic [23:0] cfg_addr;
    logic [2:0]  cfg_size;
    logic [1:0]  cfg_lane;
    logic [31:0] cfg_wdata;
    logic        cfg_rsp_valid = 1'b0;
    logic [31:0] cfg_rsp_data = '0;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] mdl_sel = '0;

    always #10 clk = ~clk;

    cfg_port_bridge uut (
        .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_we(io_we), .io_addr(io_addr),
        .io_size(io_size), .io_wdata(io_wdata), .io_done(io_done), .io_rdata(io_rdata),
        .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_size(cfg_size), .cfg_lane(cfg_lane), .cfg_wdata(cfg_wdata),
        .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_data(cfg_rsp_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] nb_of(input logic [1:0] s);
        return (s == 2'd0) ? 3'd1 : (s == 2'd1) ? 3'd2 : (s == 2'd2) ? 3'd4 : 3'd0;
    endfunction

    function automatic logic [31:0] msk_of(input logic [2:0] n);
        return (n == 3'd1) ? 32'hFF : (n == 3'd2) ? 32'hFFFF : (n == 3'd4) ? 32'hFFFF_FFFF : 32'h0;
    endfunction

    function automatic logic [31:0] rsp_of(input logic [23:0] a);
        return {a[7:0], a} ^ 32'h5A3C_9617;
    endfunction

    task automatic io_access(input bit we, input logic [15:0] port, input logic [1:0] sz,
                             input logic [31:0] wd);
        logic [2:0]  nb;
        logic [1:0]  off;
        bit          is_a, is_d, a_ok, d_ok, hs, rdy;
        logic [23:0] ea;
        logic [31:0] msk;
        string       tag;
        int          waitc;
        nb    = nb_of(sz);
        off   = port[1:0];
        is_a  = (port[15:2] == 14'h033E);
        is_d  = (port[15:2] == 14'h033F);
        a_ok  = is_a && off == 2'd0 && sz == 2'd2;
        d_ok  = is_d && nb != 3'd0 && ({2'b00, off} + {1'b0, nb}) <= 4'd4 && mdl_sel[31];
        ea    = {mdl_sel[23:8], mdl_sel[7:2], off};
        msk   = msk_of(nb);
        @(negedge clk);
        io_req = 1'b1; io_we = we; io_addr = port; io_size = sz; io_wdata = wd;
        @(negedge clk);
        io_req = 1'b0;
        if (!is_a && !is_d) begin
            for (int i = 0; i < 4; i++) begin
                chk(!io_done && !cfg_valid, "R10 unclaimed port", {30'b0, io_done, cfg_valid}, 32'h0);
                @(negedge clk);
            end
            return;
        end
        if (!d_ok) begin
            tag = a_ok ? "R2" : is_a ? "R3" : !mdl_sel[31] ? "R4" : "R5";
            chk(io_done == 1'b1, {tag, " done after one cycle"}, {31'b0, io_done}, 32'h1);
            chk(cfg_valid == 1'b0, {tag, " no request"}, {31'b0, cfg_valid}, 32'h0);
            if (!we)
                chk(io_rdata == (a_ok ? mdl_sel : 32'hFFFF_FFFF), {tag, " read data"},
                    io_rdata, a_ok ? mdl_sel : 32'hFFFF_FFFF);
            if (a_ok && we) mdl_sel = wd;
        end else begin
            hs = 1'b0;
            waitc = 0;
            while (!hs) begin
                chk(cfg_valid == 1'b1, "R7 valid held", {31'b0, cfg_valid}, 32'h1);
                chk(cfg_addr == ea && cfg_lane == off && cfg_size == nb && cfg_we == we,
                    "R6 request fields", {cfg_addr, 3'b0, cfg_size, cfg_lane}, {ea, 3'b0, nb, off});
                if (we) chk(cfg_wdata == (wd & msk), "R8 write data", cfg_wdata, wd & msk);
                chk(io_done == 1'b0, "R7 no done before handshake", {31'b0, io_done}, 32'h0);
                rdy = ($urandom % 3 == 0) || (waitc >= 4);
                cfg_ready = rdy;
                @(negedge clk);
                cfg_ready = 1'b0;
                hs = rdy;
                waitc++;
            end
            if (we) begin
                chk(io_done == 1'b1, "R8 done after handshake", {31'b0, io_done}, 32'h1);
            end else begin
                for (int i = 0; i < int'($urandom % 3); i++) begin
                    chk(io_done == 1'b0 && cfg_valid == 1'b0, "R9 waits for response",
                        {30'b0, io_done, cfg_valid}, 32'h0);
                    @(negedge clk);
                end
                chk(io_done == 1'b0, "R9 waits for response", {31'b0, io_done}, 32'h0);
                cfg_rsp_valid = 1'b1;
                cfg_rsp_data  = rsp_of(ea);
                @(negedge clk);
                cfg_rsp_valid = 1'b0;
                cfg_rsp_data  = $urandom;
                chk(io_done == 1'b1, "R9 done after response", {31'b0, io_done}, 32'h1);
                chk(io_rdata == (rsp_of(ea) & msk), "R9 read data masked", io_rdata, rsp_of(ea) & msk);
            end
        end
        @(negedge clk);
        chk(io_done == 1'b0, "R11 single pulse", {31'b0, io_done}, 32'h0);
    endtask

    initial begin
        logic [31:0] v;
        logic [15:0] p;
        int          r;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(io_done == 1'b0 && cfg_valid == 1'b0, "R1 idle after reset", {30'b0, io_done, cfg_valid}, 32'h0);
        io_access(1'b0, 16'h0CF8, 2'd2, 32'h0);            // R1 selector reads zero
        io_access(1'b1, 16'h0CF8, 2'd2, 32'h0012_3A44);    // R2 write, enable clear
        io_access(1'b0, 16'h0CF8, 2'd2, 32'h0);            // R2 readback
        io_access(1'b0, 16'h0CFC, 2'd2, 32'h0);            // R4 read disabled
        io_access(1'b1, 16'h0CFD, 2'd0, 32'hAB);           // R4 write dropped
        io_access(1'b1, 16'h0CF8, 2'd2, 32'h8012_3A47);    // R2 enable, low bits set
        io_access(1'b0, 16'h0CFC, 2'd2, 32'h0);            // R6 dword read
        for (int o = 0; o < 4; o++)
            io_access(1'b0, 16'h0CFC + 16'(o), 2'd0, 32'h0); // R6 byte lanes
        io_access(1'b1, 16'h0CFE, 2'd1, 32'hDEAD_BEEF);    // R8 word write masked
        io_access(1'b0, 16'h0CFF, 2'd1, 32'h0);            // R5 word crossing
        io_access(1'b0, 16'h0CFE, 2'd2, 32'h0);            // R5 dword crossing
        io_access(1'b0, 16'h0CFC, 2'd3, 32'h0);            // R5 reserved size
        io_access(1'b1, 16'h0CF8, 2'd0, 32'h0000_0011);    // R3 byte write ignored
        io_access(1'b1, 16'h0CF9, 2'd2, 32'h1111_1111);    // R3 offset dword ignored
        io_access(1'b0, 16'h0CFA, 2'd1, 32'h0);            // R3 read ones
        io_access(1'b0, 16'h0CF8, 2'd2, 32'h0);            // R3 selector unchanged
        io_access(1'b0, 16'h0CF7, 2'd0, 32'h0);            // R10
        io_access(1'b1, 16'h0D00, 2'd2, 32'h0);            // R10
        for (int k = 0; k < 400; k++) begin
            r = int'($urandom % 8);
            v = $urandom;
            case (r)
                0: begin v[31] = ($urandom % 4) != 0; io_access(1'b1, 16'h0CF8, 2'd2, v); end
                1: io_access(1'b0, 16'h0CF8, 2'd2, v);
                2: io_access(1'(v[8]), 16'h0CF8 + 16'(v[1:0]), v[3:2], v);
                3: begin
                    p = 16'($urandom);
                    if (p[15:3] == 13'h019F) p = p ^ 16'h0100;
                    io_access(1'(v[8]), p, v[3:2], v);
                end
                default: io_access(1'(v[8]), 16'h0CFC + 16'(v[1:0]), v[3:2], v);
            endcase
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule